// File: doc/BRIEF.md
# Interleaved Screen Address Generator

This block turns a display position into video memory fetch addresses for a 256x192 one-bit-per-pixel bitmap with 8x8 colour cells. The position is a line number (0-191) and a byte column (0-31). The pixel byte address places the fields of the line number out of their natural order. The screen third comes first, then the row within the cell, then the cell row. The attribute byte address is either a linear cell index or, in per-line-colour mode, a copy of the pixel layout in a second area.

A 3-bit mode input selects the layout: standard, alternate pixel buffer, per-line colour, or double-width high resolution. Positions come from the `line_in`/`col_in` inputs, qualified by `req`. When `walk_en` is high they come instead from an internal raster walker. The walker steps through the screen in display order and flags the end of each frame. In high-resolution mode every position yields two pixel fetches on consecutive cycles and no attribute fetch.

Top module: `scr_addr_gen`

## Requirements
- R1: In standard mode, a fetch for line L and column C gives pix_addr = {3'b010, L[7:6], L[2:0], L[5:3], C[4:0]}, that is 0x4000 plus the interleaved offset.
- R2: In standard mode, attr_addr = 0x5800 + (L/8)*32 + C, and attr_valid is high with valid.
- R3: A line with L[7:6] = 2'b11 (192 to 255) produces no fetch: valid and attr_valid stay low in the following cycle.
- R4: With mode = 3'b001, the pixel address uses base 0x6000 in place of 0x4000. The attribute address is unchanged from standard mode.
- R5: With mode = 3'b010, attr_addr = pix_addr + 0x2000, so attributes follow the pixel interleave and cover one 8x1 strip.
- R6: With mode = 3'b110, a position gives two fetches in consecutive cycles. The first comes from the 0x4000 area with hires_second = 0, and the second is the same offset in the 0x6000 area with hires_second = 1. attr_valid stays low in both. A req presented during the second cycle is ignored.
- R7: Mode values 3'b011, 3'b100, 3'b101 and 3'b111 behave exactly as standard mode.
- R8: Outputs are registered: a request sampled at a clock edge appears after that edge. With neither req nor walk_en high, valid is low.
- R9: With walk_en high, the walker visits column 0 to 31 of each line, then the next line, and returns from line 191 column 31 to line 0 column 0. frame_done pulses for one cycle together with the fetch of line 191 column 31.
- R10: After reset, valid, attr_valid, hires_second and frame_done are low and the walker starts at line 0 column 0.
- R11: With walk_en high in mode 3'b110, the walker holds each column for both fetches of the pair before it advances. frame_done comes with the second fetch of the last column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Layout select |
| walk_en | input | 1 | Use the raster walker as the position source |
| req | input | 1 | Fetch request for line_in/col_in when walk_en is low |
| line_in | input | 8 | Requested line number |
| col_in | input | 5 | Requested byte column |
| pix_addr | output | 16 | Pixel byte address |
| attr_addr | output | 16 | Attribute byte address |
| valid | output | 1 | pix_addr holds a fetch this cycle |
| attr_valid | output | 1 | attr_addr holds a fetch this cycle |
| hires_second | output | 1 | Current fetch is the second of a high-resolution pair |
| frame_done | output | 1 | Last fetch of a walked frame |

## Verification
The bench builds the block with its default parameters: bases of 0x4000, 0x6000 and 0x5800, and a last line and column of 191 and 31. These are the values the interleave and the attribute formula are defined for. With these values, a full walked frame is short enough to check every one of its 6144 positions in standard mode and every one of its 12288 fetches in high-resolution mode, including both wrap points. Direct requests cover the third boundaries, the first off-screen lines, each mode code and a request collision during the second half of a pair.

// File: rtl/scr_addr_gen.sv
`timescale 1ns/1ps
module scr_addr_gen #(
  parameter logic [15:0] PIX_BASE   = 16'h4000,
  parameter logic [15:0] ALT_BASE   = 16'h6000,
  parameter logic [15:0] ATTR_BASE  = 16'h5800,
  parameter logic [15:0] HICOL_OFS  = 16'h2000,
  parameter int          LAST_LINE  = 191,
  parameter int          LAST_COL   = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  mode,
  input  logic        walk_en,
  input  logic        req,
  input  logic [7:0]  line_in,
  input  logic [4:0]  col_in,
  output logic [15:0] pix_addr,
  output logic [15:0] attr_addr,
  output logic        valid,
  output logic        attr_valid,
  output logic        hires_second,
  output logic        frame_done
);
  localparam logic [2:0] M_ALT   = 3'b001;
  localparam logic [2:0] M_HICOL = 3'b010;
  localparam logic [2:0] M_HIRES = 3'b110;
  localparam logic [7:0] LL      = 8'(LAST_LINE);
  localparam logic [4:0] LC      = 5'(LAST_COL);
  localparam logic [15:0] PAIR_STEP = ALT_BASE - PIX_BASE;

  logic [7:0] w_line;
  logic [4:0] w_col;
  logic       phase;

  wire [7:0]  s_line = walk_en ? w_line : line_in;
  wire [4:0]  s_col  = walk_en ? w_col  : col_in;
  wire        hires  = (mode == M_HIRES);
  wire        go     = (walk_en | req) & (s_line[7:6] != 2'b11);
  wire [15:0] ilv    = {3'b000, s_line[7:6], s_line[2:0], s_line[5:3], s_col};
  wire [15:0] pix_n  = ilv + ((mode == M_ALT) ? ALT_BASE : PIX_BASE);
  wire [15:0] attr_n = (mode == M_HICOL) ? pix_n + HICOL_OFS
                                         : ATTR_BASE + {6'd0, s_line[7:3], s_col};
  wire        adv    = walk_en & (phase | ~hires);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_addr     <= '0;
      attr_addr    <= '0;
      valid        <= 1'b0;
      attr_valid   <= 1'b0;
      hires_second <= 1'b0;
      frame_done   <= 1'b0;
      phase        <= 1'b0;
      w_line       <= '0;
      w_col        <= '0;
    end else begin
      frame_done <= adv && (w_line == LL) && (w_col == LC);
      if (phase) begin
        phase        <= 1'b0;
        valid        <= 1'b1;
        attr_valid   <= 1'b0;
        hires_second <= 1'b1;
        pix_addr     <= pix_addr + PAIR_STEP;
      end else if (go) begin
        phase        <= hires;
        valid        <= 1'b1;
        attr_valid   <= ~hires;
        hires_second <= 1'b0;
        pix_addr     <= pix_n;
        attr_addr    <= hires ? 16'h0000 : attr_n;
      end else begin
        valid        <= 1'b0;
        attr_valid   <= 1'b0;
        hires_second <= 1'b0;
      end
      if (adv) begin
        if (w_col == LC) begin
          w_col  <= '0;
          w_line <= (w_line == LL) ? 8'd0 : w_line + 8'd1;
        end else begin
          w_col <= w_col + 5'd1;
        end
      end
    end
  end
endmodule

// File: rtl/scr_addr_gen_chk.sv
`timescale 1ns/1ps
module scr_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] pix_addr,
  input logic [15:0] attr_addr,
  input logic        valid,
  input logic        attr_valid,
  input logic        hires_second,
  input logic        frame_done
);
  AST_NO_OFFSCREEN: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> pix_addr[12:11] != 2'b11); // R3
  AST_ATTR_WITH_PIX: assert property (@(posedge clk) disable iff (!rst_n)
    attr_valid |-> valid); // R8
  AST_PAIR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    hires_second |-> valid && $past(valid) && !$past(hires_second)
                     && pix_addr == $past(pix_addr) + 16'h2000); // R6
  AST_PAIR_NO_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
    hires_second |-> !attr_valid); // R6
  AST_HICOL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (attr_valid && attr_addr[15:13] == 3'b011) |-> attr_addr[12:0] == pix_addr[12:0]); // R5
  AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> valid && pix_addr[4:0] == 5'd31 && pix_addr[12:11] == 2'b10); // R9
  AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R9
endmodule

bind scr_addr_gen scr_addr_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pix_addr(pix_addr), .attr_addr(attr_addr),
  .valid(valid), .attr_valid(attr_valid), .hires_second(hires_second),
  .frame_done(frame_done)
);

// File: tb/scr_addr_gen_tb_top.sv
`timescale 1ns/1ps
module scr_addr_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic walk_en = 1'b0;
  logic req = 1'b0;
  logic [7:0] line_in = 8'd0;
  logic [4:0] col_in = 5'd0;
  logic [15:0] pix_addr, attr_addr;
  logic valid, attr_valid, hires_second, frame_done;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scr_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .walk_en(walk_en), .req(req),
    .line_in(line_in), .col_in(col_in), .pix_addr(pix_addr), .attr_addr(attr_addr),
    .valid(valid), .attr_valid(attr_valid), .hires_second(hires_second),
    .frame_done(frame_done)
  );

  function automatic logic [15:0] ofs(input logic [7:0] l, input logic [4:0] c);
    return {3'b000, l[7:6], l[2:0], l[5:3], c};
  endfunction

  function automatic logic [15:0] lin_attr(input logic [7:0] l, input logic [4:0] c);
    return 16'h5800 + 16'(l / 8) * 16'd32 + 16'(c);
  endfunction

  task automatic chk(input string req_tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] m, input logic [7:0] l, input logic [4:0] c);
    @(negedge clk);
    mode = m; line_in = l; col_in = c; req = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R10", "valid", 32'(valid), 0);
    chk("R10", "attr_valid", 32'(attr_valid), 0);
    chk("R10", "hires_second", 32'(hires_second), 0);
    chk("R10", "frame_done", 32'(frame_done), 0);
  endtask

  task automatic t_std(input logic [2:0] m, input string tag);
    logic [7:0] ls[4] = '{8'd0, 8'd191, 8'd65, 8'd130};
    logic [4:0] cs[4] = '{5'd0, 5'd31, 5'd7, 5'd20};
    for (int i = 0; i < 4; i++) begin
      apply(m, ls[i], cs[i]);
      chk(tag, "valid", 32'(valid), 1);
      chk(tag, "pix_addr R1", 32'(pix_addr), 32'(16'h4000 + ofs(ls[i], cs[i])));
      chk(tag, "attr_valid R2", 32'(attr_valid), 1);
      chk(tag, "attr_addr R2", 32'(attr_addr), 32'(lin_attr(ls[i], cs[i])));
    end
    idle();
    chk("R8", "valid without req", 32'(valid), 0);
  endtask

  task automatic t_offscreen();
    apply(3'd0, 8'd192, 5'd0);
    chk("R3", "valid line 192", 32'(valid), 0);
    chk("R3", "attr_valid line 192", 32'(attr_valid), 0);
    apply(3'd2, 8'd255, 5'd31);
    chk("R3", "valid line 255", 32'(valid), 0);
    idle();
  endtask

  task automatic t_alt();
    apply(3'b001, 8'd100, 5'd13);
    chk("R4", "pix_addr", 32'(pix_addr), 32'(16'h6000 + ofs(8'd100, 5'd13)));
    chk("R4", "attr_addr", 32'(attr_addr), 32'(lin_attr(8'd100, 5'd13)));
    apply(3'b000, 8'd100, 5'd13);
    chk("R4", "pix_addr back to 0x4000", 32'(pix_addr), 32'(16'h4000 + ofs(8'd100, 5'd13)));
    idle();
  endtask

  task automatic t_hicol();
    apply(3'b010, 8'd75, 5'd22);
    chk("R5", "pix_addr", 32'(pix_addr), 32'(16'h4000 + ofs(8'd75, 5'd22)));
    chk("R5", "attr_addr", 32'(attr_addr), 32'(16'h6000 + ofs(8'd75, 5'd22)));
    chk("R5", "attr_valid", 32'(attr_valid), 1);
    apply(3'b010, 8'd76, 5'd22);
    chk("R5", "attr next line", 32'(attr_addr), 32'(16'h6000 + ofs(8'd76, 5'd22)));
    idle();
  endtask

  task automatic t_hires();
    apply(3'b110, 8'd77, 5'd9);
    chk("R6", "first pix", 32'(pix_addr), 32'(16'h4000 + ofs(8'd77, 5'd9)));
    chk("R6", "first hires_second", 32'(hires_second), 0);
    chk("R6", "first attr_valid", 32'(attr_valid), 0);
    chk("R6", "first valid", 32'(valid), 1);
    apply(3'b110, 8'd5, 5'd3);
    chk("R6", "second pix", 32'(pix_addr), 32'(16'h6000 + ofs(8'd77, 5'd9)));
    chk("R6", "second hires_second", 32'(hires_second), 1);
    chk("R6", "second attr_valid", 32'(attr_valid), 0);
    idle();
    chk("R6", "ignored req gives no fetch", 32'(valid), 0);
  endtask

  task automatic t_unknown();
    logic [2:0] ms[4] = '{3'b011, 3'b100, 3'b101, 3'b111};
    for (int i = 0; i < 4; i++) begin
      apply(ms[i], 8'd150, 5'd4);
      chk("R7", "pix_addr", 32'(pix_addr), 32'(16'h4000 + ofs(8'd150, 5'd4)));
      chk("R7", "attr_addr", 32'(attr_addr), 32'(lin_attr(8'd150, 5'd4)));
      chk("R7", "attr_valid", 32'(attr_valid), 1);
      apply(ms[i], 8'd151, 5'd4);
      chk("R7", "no pair", 32'(hires_second), 0);
    end
    idle();
  endtask

  task automatic t_walk_std();
    int bad = 0;
    @(negedge clk);
    mode = 3'd0; walk_en = 1'b1; req = 1'b0;
    for (int k = 0; k < 6144; k++) begin
      logic [7:0] l;
      logic [4:0] c;
      l = 8'(k / 32);
      c = 5'(k % 32);
      @(posedge clk);
      #1;
      if (pix_addr !== 16'h4000 + ofs(l, c) || attr_addr !== lin_attr(l, c) ||
          valid !== 1'b1 || frame_done !== (k == 6143)) begin
        bad++;
        if (bad < 4)
          chk("R9", $sformatf("walk index %0d pix", k), 32'(pix_addr), 32'(16'h4000 + ofs(l, c)));
      end
    end
    chk("R9", "walk mismatches", 32'(bad), 0);
    @(negedge clk);
    walk_en = 1'b0;
    @(posedge clk);
    #1;
    chk("R9", "frame_done one pulse", 32'(frame_done), 0);
  endtask

  task automatic t_walk_hires();
    int bad = 0;
    @(negedge clk);
    mode = 3'b110; walk_en = 1'b1;
    for (int k = 0; k < 12288; k++) begin
      logic [7:0] l;
      logic [4:0] c;
      logic [15:0] e;
      l = 8'((k / 2) / 32);
      c = 5'((k / 2) % 32);
      e = ((k % 2) == 1 ? 16'h6000 : 16'h4000) + ofs(l, c);
      @(posedge clk);
      #1;
      if (pix_addr !== e || hires_second !== 1'((k % 2) == 1) || attr_valid !== 1'b0 ||
          valid !== 1'b1 || frame_done !== (k == 12287)) begin
        bad++;
        if (bad < 4)
          chk("R11", $sformatf("hires walk index %0d pix", k), 32'(pix_addr), 32'(e));
      end
    end
    chk("R11", "hires walk mismatches", 32'(bad), 0);
    @(negedge clk);
    walk_en = 1'b0;
    mode = 3'd0;
    @(posedge clk);
    #1;
    chk("R11", "frame_done cleared", 32'(frame_done), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_std(3'd0, "R1");
    t_offscreen();
    t_alt();
    t_hicol();
    t_hires();
    t_unknown();
    t_walk_std();
    t_walk_hires();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule